// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer with Blank Check

This block erases an external byte-wide, electrically erasable flash device as a whole and then proves that the erase worked. When the host pulses `start`, the sequencer selects the device and turns on two level-switch enables. One raises one address pin to the super-voltage and the other raises the programming supply. It waits out a setup time and then drives a single long low pulse on the device strobe. It keeps the high levels for a hold time, drops them, and waits a recovery time before it issues any read.

Next it walks the whole address space from zero upward, reading each location with chip select and output enable low. Every byte must read as all ones. The walk stops at the first byte that does not, or after the last address. The sequencer then raises `done` for one cycle, with `pass` giving the verdict. `pass` keeps that value until the next run starts. The controller never drives the device data bus: it only samples `dataIn`. The high-voltage drivers and the storage array are outside this block.

Every interval is a parameter in clock cycles. Real silicon needs an erase pulse of 100 to 500 ms and setup, hold and recovery times of at least 1 µs. A simulation can use shortened values instead.

Top module: `flash_wipe_seq`

## Requirements
- R1: After reset, and whenever idle, busy, done and pass are 0 (pass keeps the last verdict once a run has finished). ceN, oeN and strobeN are 1, both level enables are 0 and addr is 0.
- R2: When start is 1 on a clock edge while idle, the following cycle shows busy=1, ceN=0, oeN=1, strobeN=1 and both level enables at 1. This setup state lasts exactly SETUP_CYC cycles before strobeN falls.
- R3: strobeN stays 0 for exactly PULSE_CYC cycles. Throughout the pulse, ceN=0, oeN=1 and both level enables are 1. strobeN is never 0 in any other condition.
- R4: After strobeN rises, ceN=0 and both enables stay at 1 for HOLD_CYC cycles. Then the enables drop to 0 and ceN=oeN=1 for RECOV_CYC cycles before the first read.
- R5: The blank check presents addresses 0, 1, 2, … on addr, each with ceN=oeN=0 for READ_CYC cycles. dataIn is sampled in the last of those cycles. Both level enables are 0 whenever oeN is 0.
- R6: If every byte reads as all ones (FFh for 8-bit data), done is 1 for exactly one cycle right after the read window of the highest address. In that cycle pass=1, and pass stays 1 until the next start.
- R7: The first byte that is not all ones ends the check. done is 1 for one cycle right after that address's read window, with pass=0, and no higher address is read.
- R8: start has no effect while busy is 1. Both the timing and the verdict of the run in progress are unchanged.
- R9: pass reads 0 from the first cycle of a new run until that run's done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| dataIn | input | DATA_W | Data read from the device |
| busy | output | 1 | A run is in progress (done cycle included) |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Verdict: 1 when every byte read as all ones |
| ceN | output | 1 | Device chip select, active low |
| oeN | output | 1 | Device output enable, active low |
| strobeN | output | 1 | Device erase strobe, active low |
| hvA9En | output | 1 | Enables the super-voltage switch on the erase-select address pin |
| vppHiEn | output | 1 | Enables the high programming-supply switch |
| addr | output | ADDR_W | Device address during the blank check |

## Verification
The sequencer state is visible almost directly at the pins, because every pin is a register decoded from the next state. A wrong phase or a timer loaded with the wrong length shows up on the strobe, select or enable pins in the very cycle it occurs. The reference model compares those pins on every clock. A wrong address counter or a bad compare result appears later. It shows as a wrong addr during the walk, or as done arriving at the wrong cycle with the wrong pass value, at most one read window after the byte concerned. Bytes stuck at the first address, a middle address and the last address separate an early stop from a missed stop.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_RECOV,
    ST_READ,
    ST_DONE
  } wipeState_e;

  typedef enum logic [2:0] {
    TM_SETUP,
    TM_PULSE,
    TM_HOLD,
    TM_RECOV,
    TM_READ
  } tmrSel_e;

  typedef struct packed {
    logic    tmrLoad;
    tmrSel_e tmrSel;
    logic    addrClr;
    logic    addrInc;
    logic    passClr;
    logic    passLatch;
  } wipeStrobe_t;

endpackage

// File: rtl/wipe_datapath.sv
module wipe_datapath
  import wipe_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 64,
  parameter int PULSE_CYC = 5_500_000,
  parameter int HOLD_CYC  = 64,
  parameter int RECOV_CYC = 64,
  parameter int READ_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wipeStrobe_t       stb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              tmrZero,
  output logic              addrLast,
  output logic              byteBlank,
  output logic [ADDR_W-1:0] addr,
  output logic              pass
);

  localparam int MAX_AB  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CD  = (HOLD_CYC > RECOV_CYC) ? HOLD_CYC : RECOV_CYC;
  localparam int MAX_ABC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAX_ALL = (MAX_ABC > READ_CYC) ? MAX_ABC : READ_CYC;
  localparam int TMR_W   = $clog2(MAX_ALL + 1);

  logic [TMR_W-1:0]  tmr;
  logic [TMR_W-1:0]  loadVal;
  logic [ADDR_W-1:0] addrQ;
  logic              passQ;

  // one down-counter serves every timed phase; control picks the reload
  always_comb begin
    unique case (stb.tmrSel)
      TM_SETUP: loadVal = TMR_W'(SETUP_CYC - 1);
      TM_PULSE: loadVal = TMR_W'(PULSE_CYC - 1);
      TM_HOLD:  loadVal = TMR_W'(HOLD_CYC - 1);
      TM_RECOV: loadVal = TMR_W'(RECOV_CYC - 1);
      default:  loadVal = TMR_W'(READ_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (stb.tmrLoad) begin
      tmr <= loadVal;
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (stb.addrClr) begin
      addrQ <= '0;
    end else if (stb.addrInc) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passQ <= 1'b0;
    end else if (stb.passClr) begin
      passQ <= 1'b0;
    end else if (stb.passLatch) begin
      passQ <= byteBlank;
    end
  end

  assign tmrZero   = (tmr == '0);
  assign addrLast  = &addrQ;
  assign byteBlank = &dataIn;
  assign addr      = addrQ;
  assign pass      = passQ;

endmodule

// File: rtl/wipe_ctrl.sv
module wipe_ctrl
  import wipe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        tmrZero,
  input  logic        addrLast,
  input  logic        byteBlank,
  output wipeStrobe_t stb,
  output logic        busy,
  output logic        done,
  output logic        ceN,
  output logic        oeN,
  output logic        strobeN,
  output logic        hvA9En,
  output logic        vppHiEn
);

  wipeState_e state;
  wipeState_e stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    stb.tmrSel = TM_SETUP;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext   = ST_SETUP;
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_SETUP;
          stb.addrClr = 1'b1;
          stb.passClr = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tmrZero) begin
          stateNext   = ST_PULSE;
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmrZero) begin
          stateNext   = ST_HOLD;
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmrZero) begin
          stateNext   = ST_RECOV;
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_RECOV;
        end
      end
      ST_RECOV: begin
        if (tmrZero) begin
          stateNext   = ST_READ;
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_READ;
        end
      end
      ST_READ: begin
        if (tmrZero) begin
          if (!byteBlank || addrLast) begin
            stateNext     = ST_DONE;
            stb.passLatch = 1'b1;
            stb.addrClr   = 1'b1;
          end else begin
            stb.addrInc = 1'b1;
            stb.tmrLoad = 1'b1;
            stb.tmrSel  = TM_READ;
          end
        end
      end
      ST_DONE: begin
        stateNext = ST_IDLE;
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  // device pins are registered from the next state: no decode glitches reach the device
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ceN     <= 1'b1;
      oeN     <= 1'b1;
      strobeN <= 1'b1;
      hvA9En  <= 1'b0;
      vppHiEn <= 1'b0;
    end else begin
      busy    <= (stateNext != ST_IDLE);
      done    <= (stateNext == ST_DONE);
      ceN     <= !(stateNext inside {ST_SETUP, ST_PULSE, ST_HOLD, ST_READ});
      oeN     <= (stateNext != ST_READ);
      strobeN <= (stateNext != ST_PULSE);
      hvA9En  <= (stateNext inside {ST_SETUP, ST_PULSE, ST_HOLD});
      vppHiEn <= (stateNext inside {ST_SETUP, ST_PULSE, ST_HOLD});
    end
  end

endmodule

// File: rtl/flash_wipe_seq.sv
module flash_wipe_seq
  import wipe_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 64,
  parameter int PULSE_CYC = 5_500_000,
  parameter int HOLD_CYC  = 64,
  parameter int RECOV_CYC = 64,
  parameter int READ_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] dataIn,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              ceN,
  output logic              oeN,
  output logic              strobeN,
  output logic              hvA9En,
  output logic              vppHiEn,
  output logic [ADDR_W-1:0] addr
);

  wipeStrobe_t stb;
  logic        tmrZero;
  logic        addrLast;
  logic        byteBlank;

  wipe_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .tmrZero   (tmrZero),
    .addrLast  (addrLast),
    .byteBlank (byteBlank),
    .stb       (stb),
    .busy      (busy),
    .done      (done),
    .ceN       (ceN),
    .oeN       (oeN),
    .strobeN   (strobeN),
    .hvA9En    (hvA9En),
    .vppHiEn   (vppHiEn)
  );

  wipe_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RECOV_CYC (RECOV_CYC),
    .READ_CYC  (READ_CYC)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .dataIn    (dataIn),
    .tmrZero   (tmrZero),
    .addrLast  (addrLast),
    .byteBlank (byteBlank),
    .addr      (addr),
    .pass      (pass)
  );

endmodule

// File: rtl/wipe_chk.sv
module wipe_chk #(
  parameter int SETUP_CYC = 64,
  parameter int PULSE_CYC = 5_500_000,
  parameter int RECOV_CYC = 64
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic pass,
  input logic ceN,
  input logic oeN,
  input logic strobeN,
  input logic hvA9En,
  input logic vppHiEn
);

  logic [31:0] preCnt;
  logic [31:0] lowCnt;
  logic [31:0] recCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      lowCnt <= '0;
      recCnt <= '0;
    end else begin
      preCnt <= !hvA9En ? '0 : (strobeN ? preCnt + 1 : preCnt);
      lowCnt <= strobeN ? '0 : lowCnt + 1;
      recCnt <= (busy && !hvA9En && oeN) ? recCnt + 1 : '0;
    end
  end

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ceN && oeN && strobeN && !hvA9En && !vppHiEn && !done));

  a_r2_setup_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeN) |-> (preCnt == 32'(SETUP_CYC)));

  a_r3_strobe_cond: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> (hvA9En && vppHiEn && !ceN && oeN));

  a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeN) |-> (lowCnt == 32'(PULSE_CYC)));

  a_r4_recovery: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oeN) |-> (recCnt == 32'(RECOV_CYC)));

  a_r5_read_low_level: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (!hvA9En && !vppHiEn && !ceN));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  a_r9_pass_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !pass);

endmodule

bind flash_wipe_seq wipe_chk #(
  .SETUP_CYC (SETUP_CYC),
  .PULSE_CYC (PULSE_CYC),
  .RECOV_CYC (RECOV_CYC)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .pass    (pass),
  .ceN     (ceN),
  .oeN     (oeN),
  .strobeN (strobeN),
  .hvA9En  (hvA9En),
  .vppHiEn (vppHiEn)
);

// File: tb/tb_flash_wipe_seq.sv
`timescale 1ns/1ps
module tb_flash_wipe_seq;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int SC    = 5;
  localparam int PC    = 12;
  localparam int HC    = 4;
  localparam int RC    = 6;
  localparam int RD    = 3;
  localparam int BASE  = SC + PC + HC + RC;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] dataIn;
  logic          busy, done, pass, ceN, oeN, strobeN, hvA9En, vppHiEn;
  logic [AW-1:0] addr;

  always #10 clk = ~clk;

  flash_wipe_seq #(
    .ADDR_W (AW), .DATA_W (DW), .SETUP_CYC (SC), .PULSE_CYC (PC),
    .HOLD_CYC (HC), .RECOV_CYC (RC), .READ_CYC (RD)
  ) dut (
    .clk (clk), .rstN (rstN), .start (start), .dataIn (dataIn),
    .busy (busy), .done (done), .pass (pass), .ceN (ceN), .oeN (oeN),
    .strobeN (strobeN), .hvA9En (hvA9En), .vppHiEn (vppHiEn), .addr (addr)
  );

  // behavioural flash device
  logic [DW-1:0] mem [DEPTH];
  int stuckIdx = -1;

  always @(negedge strobeN) begin
    if (hvA9En && vppHiEn && !ceN && oeN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = (i == stuckIdx) ? 8'hEF : 8'hFF;
    end
  end

  assign dataIn = (!ceN && !oeN) ? mem[addr] : 8'h00;

  // reference timeline
  int  t = -1;
  int  doneT = 0;
  bit  expPass = 1'b0;
  bit  lastPass = 1'b0;
  int  vectors = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      t = -1;
      lastPass = 1'b0;
    end else if (t < 0) begin
      if (start) begin
        int f;
        f = (stuckIdx < 0) ? DEPTH - 1 : stuckIdx;
        doneT = BASE + (f + 1) * RD;
        expPass = (stuckIdx < 0);
        t = 0;
      end
    end else if (t == doneT) begin
      t = -1;
      lastPass = expPass;
    end else begin
      t++;
    end
  end

  function automatic string tagNow();
    if (t < 0) return "R1";
    if (t < SC) return "R2";
    if (t < SC + PC) return "R3";
    if (t < BASE) return "R4";
    if (t < doneT) return "R5";
    return expPass ? "R6" : "R7";
  endfunction

  task automatic chk(input string tag, input string name, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual=%0d expected=%0d", tag, name, t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit run, rd;
      string tg;
      run = (t >= 0);
      rd  = run && (t >= BASE) && (t < doneT);
      tg  = tagNow();
      chk(tg, "busy", int'(busy), int'(run));
      chk(tg, "done", int'(done), int'(run && t == doneT));
      // R9: pass is 0 during a run until its done cycle
      chk(run && t < doneT ? "R9" : tg, "pass", int'(pass),
          int'(run ? (t == doneT && expPass) : lastPass));
      chk(tg, "ceN", int'(ceN), int'(!((run && t < SC + PC + HC) || rd)));
      chk(tg, "oeN", int'(oeN), int'(!rd));
      chk(tg, "strobeN", int'(strobeN), int'(!(run && t >= SC && t < SC + PC)));
      chk(tg, "hvA9En", int'(hvA9En), int'(run && t < SC + PC + HC));
      chk(tg, "vppHiEn", int'(vppHiEn), int'(run && t < SC + PC + HC));
      chk(tg, "addr", int'(addr), rd ? (t - BASE) / RD : 0);
    end
  end

  task automatic fillJunk();
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 37 + 1);
  endtask

  // runs one erase+check; strayAt >= 0 pulses start again that many cycles in
  task automatic doRun(input int stuck, input int strayAt);
    int n, expN;
    stuckIdx = stuck;
    fillJunk();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 1000) begin
      if (n == strayAt) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    expN = BASE + ((stuck < 0 ? DEPTH - 1 : stuck) + 1) * RD;
    // R6, R7, R8: done arrives at the cycle fixed by the parameters and the stuck byte
    chk(stuck < 0 ? (strayAt >= 0 ? "R8" : "R6") : "R7", "doneCycle", n, expN);
    chk(stuck < 0 ? "R6" : "R7", "verdict", int'(pass), int'(stuck < 0));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "resetPins", int'({busy, done, pass, ceN, oeN, strobeN, hvA9En, vppHiEn}),
        int'(8'b0001_1100));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    doRun(-1, 30);      // clean erase, stray start mid-check (R8)
    doRun(9, -1);       // R7: byte stuck mid-array
    doRun(DEPTH - 1, 8); // R7: stuck at last address, stray start during pulse
    doRun(0, -1);       // R7: stuck at first address
    doRun(-1, -1);      // R6, R9: clean run after a failing one
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule